// File: doc/BRIEF.md
# Flag-Conditional Branch Unit

This unit resolves the three two-byte conditional branches of an 8-bit microcontroller whose program memory has 512 locations. The three branches are: jump when the zero flag is clear, jump when the overflow flag is clear, and jump when the zero flag is set. The sequencer fetches both instruction bytes. It then presents the opcode byte, the operand byte, the current zero and overflow flags and the 9-bit program counter of the instruction, and raises a start strobe for one cycle. One cycle later the unit returns the next program counter and a taken flag, together with a one-cycle done pulse.

A single operand byte cannot reach all 512 locations. The unit therefore takes the ninth target bit from bit 0 of the opcode byte, so each branch kind occupies two adjacent opcode values. When a branch is not taken, or the opcode is not one of the three branches, the unit returns the address just past the operand byte. The unit has no flag outputs, so the flags are never altered by a branch.

The control is a two-state machine. `ST_IDLE` is the waiting state. `ST_REPORT` is the state in which done is high. The machine makes these transitions:
- IDLE to REPORT on start.
- REPORT to REPORT on a start that arrives during the report cycle.
- REPORT to IDLE without start.
- IDLE to IDLE without start.

Top module: `branch_unit`

## Requirements
- R1: Opcode bits [7:1] select the branch kind: 0x50 is jump-if-zero-clear (opcodes 0xA0/0xA1), 0x51 is jump-if-overflow-clear (0xA2/0xA3), 0x52 is jump-if-zero-set (0xA4/0xA5); every other value is a non-branch.
- R2: Jump-if-zero-clear is taken exactly when the zero flag is 0, whatever the overflow flag is.
- R3: Jump-if-overflow-clear is taken exactly when the overflow flag is 0, whatever the zero flag is.
- R4: Jump-if-zero-set is taken exactly when the zero flag is 1, whatever the overflow flag is.
- R5: A taken branch sets the next PC to {opcode bit 0, operand byte}, so addresses 0x000 through 0x1FF are all reachable.
- R6: A branch that is not taken sets the next PC to the current PC plus 2, modulo 512.
- R7: A non-branch opcode gives taken = 0, the PC-plus-2 fall-through and a done pulse.
- R8: next PC, taken and a one-cycle done pulse appear in the cycle after each start. A start during the report cycle extends done by one cycle and delivers its own result.
- R9: Without start, next PC and taken hold their values, and changes on the inputs have no effect on them.
- R10: During and right after reset, done is 0, taken is 0 and next PC is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to resolve the presented instruction |
| opcode_i | input | 8 | First instruction byte |
| operand_i | input | 8 | Second instruction byte (low 8 target bits) |
| flag_z_i | input | 1 | Current zero flag |
| flag_v_i | input | 1 | Current overflow flag |
| pc_i | input | 9 | Address of the branch instruction |
| next_pc_o | output | 9 | Resolved next program counter |
| taken_o | output | 1 | High when the branch was taken |
| done_o | output | 1 | One-cycle result strobe |

## Verification
Two things can fall in the same cycle: the report of one result, and the acceptance of the next start. The bench provokes this by raising a second start in the same cycle in which done is high for the first. It then judges the following:
- done stays high for exactly two cycles.
- The first result is visible during the first of those cycles.
- The second result replaces it in the next cycle.
- done falls once no further start arrives.

Target wrap is a second overlap. A not-taken branch at address 0x1FE, or at 0x1FF, must fall through to 0x000 or 0x001. A taken branch to 0x1FF must not be confused with that fall-through.

// File: rtl/branch_unit_pkg.sv
package branch_unit_pkg;

    typedef enum logic [1:0] {
        BR_NONE,
        BR_ZCLR,
        BR_VCLR,
        BR_ZSET
    } br_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } br_state_e;

endpackage

// File: rtl/br_decode.sv
module br_decode
    import branch_unit_pkg::*;
#(
    parameter int CLS_W = 7,
    parameter logic [CLS_W-1:0] CLS_ZCLR = 7'h50,
    parameter logic [CLS_W-1:0] CLS_VCLR = 7'h51,
    parameter logic [CLS_W-1:0] CLS_ZSET = 7'h52
) (
    input  logic [CLS_W-1:0] cls_i,
    output br_kind_e         kind_o
);

    always_comb begin
        if (cls_i == CLS_ZCLR) begin
            kind_o = BR_ZCLR;
        end else if (cls_i == CLS_VCLR) begin
            kind_o = BR_VCLR;
        end else if (cls_i == CLS_ZSET) begin
            kind_o = BR_ZSET;
        end else begin
            kind_o = BR_NONE;
        end
    end

endmodule

// File: rtl/br_cond.sv
module br_cond
    import branch_unit_pkg::*;
(
    input  br_kind_e kind_i,
    input  logic     flag_z_i,
    input  logic     flag_v_i,
    output logic     take_o
);

    always_comb begin
        unique case (kind_i)
            BR_ZCLR: take_o = ~flag_z_i;
            BR_VCLR: take_o = ~flag_v_i;
            BR_ZSET: take_o = flag_z_i;
            BR_NONE: take_o = 1'b0;
            default: take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/br_target.sv
module br_target #(
    parameter int PC_W   = 9,
    parameter int DATA_W = 8,
    parameter int STEP   = 2
) (
    input  logic [PC_W-DATA_W-1:0] hi_i,
    input  logic [DATA_W-1:0]      lo_i,
    input  logic [PC_W-1:0]        pc_i,
    input  logic                   take_i,
    output logic [PC_W-1:0]        next_pc_o
);

    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    logic [PC_W-1:0] target;
    logic [PC_W-1:0] fall;

    assign target = {hi_i, lo_i};
    assign fall   = pc_i + STEP_V;

    always_comb begin
        next_pc_o = take_i ? target : fall;
    end

endmodule

// File: rtl/branch_unit.sv
module branch_unit
    import branch_unit_pkg::*;
#(
    parameter int PC_W   = 9,
    parameter int DATA_W = 8,
    parameter int INSN_BYTES = 2,
    parameter logic [DATA_W-(PC_W-DATA_W)-1:0] CLS_ZCLR = 7'h50,
    parameter logic [DATA_W-(PC_W-DATA_W)-1:0] CLS_VCLR = 7'h51,
    parameter logic [DATA_W-(PC_W-DATA_W)-1:0] CLS_ZSET = 7'h52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] opcode_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              flag_z_i,
    input  logic              flag_v_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              taken_o,
    output logic              done_o
);

    localparam int HI_W  = PC_W - DATA_W;
    localparam int CLS_W = DATA_W - HI_W;

    br_state_e       state_q;
    br_state_e       state_d;
    br_kind_e        kind;
    logic            take;
    logic [PC_W-1:0] resolved_pc;
    logic [PC_W-1:0] next_pc_q;
    logic            taken_q;

    br_decode #(
        .CLS_W   (CLS_W),
        .CLS_ZCLR(CLS_ZCLR),
        .CLS_VCLR(CLS_VCLR),
        .CLS_ZSET(CLS_ZSET)
    ) u_decode (
        .cls_i (opcode_i[DATA_W-1:HI_W]),
        .kind_o(kind)
    );

    br_cond u_cond (
        .kind_i  (kind),
        .flag_z_i(flag_z_i),
        .flag_v_i(flag_v_i),
        .take_o  (take)
    );

    br_target #(
        .PC_W  (PC_W),
        .DATA_W(DATA_W),
        .STEP  (INSN_BYTES)
    ) u_target (
        .hi_i     (opcode_i[HI_W-1:0]),
        .lo_i     (operand_i),
        .pc_i     (pc_i),
        .take_i   (take),
        .next_pc_o(resolved_pc)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = start_i ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = start_i ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers: captured only on a start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_q <= '0;
            taken_q   <= 1'b0;
        end else if (start_i) begin
            next_pc_q <= resolved_pc;
            taken_q   <= take;
        end
    end

    assign next_pc_o = next_pc_q;
    assign taken_o   = taken_q;
    assign done_o    = (state_q == ST_REPORT);

endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk #(
    parameter int PC_W   = 9,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [DATA_W-1:0] opcode_i,
    input logic [DATA_W-1:0] operand_i,
    input logic              flag_z_i,
    input logic [PC_W-1:0]   pc_i,
    input logic [PC_W-1:0]   next_pc_o,
    input logic              taken_o,
    input logic              done_o
);

    localparam logic [PC_W-1:0] TWO = PC_W'(2);

    // R8
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(next_pc_o) && $stable(taken_o)));

    // R5
    target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!taken_o || next_pc_o == {$past(opcode_i[0]), $past(operand_i)}));

    // R6
    fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (taken_o || next_pc_o == $past(pc_i) + TWO));

    // R2
    zclr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && opcode_i[7:1] == 7'h50 && flag_z_i) |=> !taken_o);

endmodule

bind branch_unit branch_unit_chk #(
    .PC_W  (PC_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .opcode_i (opcode_i),
    .operand_i(operand_i),
    .flag_z_i (flag_z_i),
    .pc_i     (pc_i),
    .next_pc_o(next_pc_o),
    .taken_o  (taken_o),
    .done_o   (done_o)
);

// File: tb/test_branch_unit.sv
module test_branch_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] opcode_i = 8'h00;
    logic [7:0] operand_i = 8'h00;
    logic       flag_z_i = 1'b0;
    logic       flag_v_i = 1'b0;
    logic [8:0] pc_i = 9'h000;
    logic [8:0] next_pc_o;
    logic       taken_o;
    logic       done_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    branch_unit i_branch_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .opcode_i (opcode_i),
        .operand_i(operand_i),
        .flag_z_i (flag_z_i),
        .flag_v_i (flag_v_i),
        .pc_i     (pc_i),
        .next_pc_o(next_pc_o),
        .taken_o  (taken_o),
        .done_o   (done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] op, input logic [7:0] opr,
                         input logic z, input logic v, input logic [8:0] pc);
        opcode_i  = op;
        operand_i = opr;
        flag_z_i  = z;
        flag_v_i  = v;
        pc_i      = pc;
        start_i   = 1'b1;
    endtask

    // one isolated request; checks the result one cycle later
    task automatic one(input string req, input logic [7:0] op, input logic [7:0] opr,
                       input logic z, input logic v, input logic [8:0] pc,
                       input logic exp_tk, input logic [8:0] exp_pc);
        @(negedge clk);
        drive(op, opr, z, v, pc);
        @(negedge clk);
        start_i = 1'b0;
        chk({req, " done"}, int'(done_o), 1);
        chk({req, " taken"}, int'(taken_o), int'(exp_tk));
        chk({req, " next_pc"}, int'(next_pc_o), int'(exp_pc));
        @(negedge clk);
        chk({req, " done drops"}, int'(done_o), 0);
    endtask

    task automatic t_reset();
        chk("R10 done", int'(done_o), 0);
        chk("R10 taken", int'(taken_o), 0);
        chk("R10 next_pc", int'(next_pc_o), 0);
    endtask

    task automatic t_zclr();
        one("R2 z0", 8'hA0, 8'h34, 1'b0, 1'b1, 9'h010, 1'b1, 9'h034);
        one("R2 z1", 8'hA1, 8'h34, 1'b1, 1'b0, 9'h010, 1'b0, 9'h012);
    endtask

    task automatic t_vclr();
        one("R3 v0", 8'hA3, 8'h56, 1'b1, 1'b0, 9'h020, 1'b1, 9'h156);
        one("R3 v1", 8'hA2, 8'h56, 1'b0, 1'b1, 9'h020, 1'b0, 9'h022);
    endtask

    task automatic t_zset();
        one("R4 z1", 8'hA4, 8'h78, 1'b1, 1'b1, 9'h030, 1'b1, 9'h078);
        one("R4 z0", 8'hA5, 8'h78, 1'b0, 1'b0, 9'h030, 1'b0, 9'h032);
    endtask

    task automatic t_reach();
        one("R5 top", 8'hA1, 8'hFF, 1'b0, 1'b0, 9'h100, 1'b1, 9'h1FF);
        one("R5 bottom", 8'hA4, 8'h00, 1'b1, 1'b0, 9'h1F0, 1'b1, 9'h000);
    endtask

    task automatic t_wrap();
        one("R6 wrap0", 8'hA0, 8'h11, 1'b1, 1'b0, 9'h1FE, 1'b0, 9'h000);
        one("R6 wrap1", 8'hA4, 8'h11, 1'b0, 1'b0, 9'h1FF, 1'b0, 9'h001);
    endtask

    task automatic t_nonbranch();
        one("R7 A6", 8'hA6, 8'h22, 1'b0, 1'b0, 9'h040, 1'b0, 9'h042);
        one("R7 21", 8'h21, 8'h22, 1'b1, 1'b1, 9'h0FF, 1'b0, 9'h101);
        one("R1 B0", 8'hB0, 8'h22, 1'b0, 1'b0, 9'h050, 1'b0, 9'h052);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        drive(8'hA0, 8'h9A, 1'b0, 1'b0, 9'h060);
        @(negedge clk);
        chk("R8 b2b first done", int'(done_o), 1);
        chk("R8 b2b first pc", int'(next_pc_o), 9'h09A);
        drive(8'hA4, 8'h9A, 1'b0, 1'b0, 9'h070);
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 b2b second done", int'(done_o), 1);
        chk("R8 b2b second taken", int'(taken_o), 0);
        chk("R8 b2b second pc", int'(next_pc_o), 9'h072);
        @(negedge clk);
        chk("R8 b2b done drops", int'(done_o), 0);
    endtask

    task automatic t_hold();
        one("R9 setup", 8'hA2, 8'hC3, 1'b0, 1'b0, 9'h080, 1'b1, 9'h0C3);
        @(negedge clk);
        opcode_i  = 8'hA4;
        operand_i = 8'h01;
        flag_z_i  = 1'b0;
        pc_i      = 9'h123;
        @(negedge clk);
        @(negedge clk);
        chk("R9 hold pc", int'(next_pc_o), 9'h0C3);
        chk("R9 hold taken", int'(taken_o), 1);
        chk("R9 no done", int'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zclr();
        t_vclr();
        t_zset();
        t_reach();
        t_wrap();
        t_nonbranch();
        t_back_to_back();
        t_hold();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule